// File: doc/BRIEF.md
# Multi-Level Page Table Walker

The walker turns a 64-bit input address into a physical address by reading 64-bit descriptors from hierarchical translation tables. Two table regions are configured, a low one and a high one. Each has a size field, a granule code, a base register and a disable bit. On each request the walker decides which region covers the address, taking top-byte-ignore into account. It then derives the first lookup level from the region size and the granule. From there it reads one descriptor per level over a single-outstanding memory read port, until it reaches a leaf or detects a fault.

A client issues a request with a valid/ready handshake and waits for a one-cycle `done` pulse. At that pulse the result registers hold the physical address, the size mask of the mapping that was hit, the granted permissions and a fault code. On a fault they also hold the address of the descriptor that caused it. The descriptor store sits behind the memory port. The walker keeps no cached results and performs a single stage of translation.

Top module: `ptw_walker`

## Requirements
- R1: Input bit 55 chooses which top-byte-ignore enable applies (1: `cfg_tbi_hi`, 0: `cfg_tbi_lo`). When that enable is set, bits [63:56] take no part in the region test. Otherwise the test covers bits [63:64-size], using the raw size field.
- R2: The low region wins when its size is non-zero and the tested bits are all zero. Otherwise the high region wins when its size is non-zero and the tested bits are all one. Otherwise a region with size zero takes the address, the low one tried first. If none applies, the walker reports fault code 2'b01 (translation) with fault address 0 and issues no memory read.
- R3: A selected region whose disable bit is set gives fault 2'b01 with fault address 0 and no memory read.
- R4: Granule code 2'b00 selects 4 KiB, 2'b01 selects 16 KiB and 2'b1x selects 64 KiB. The walk uses the size field clamped to [16,48]. The start level is 4 - (inputsize-4)/stride, where stride = log2(granule)-3 and inputsize = 64 - size. A start level of 4 gives fault 2'b01 with no memory read.
- R5: The first table base is region base bits [47:0] with the low inputsize-stride*(4-start) bits cleared. Each descriptor is read at base + index*8, so the read address is 8-byte aligned. The index is input bits [shift+stride-1:shift], shortened so that it stays below inputsize, where shift = log2(granule) + (3-level)*stride.
- R6: Descriptor bits [1:0] give the type. With bit 0 clear the descriptor is invalid. 2'b11 is a table at levels 0-2 and a page at level 3. 2'b01 is a block at levels 1-2 and is reserved at levels 0 and 3. A table's next base is descriptor bits [47:log2(granule)].
- R7: A page or block ends the walk with fault 2'b00. `res_mask` is 2^shift - 1 and `res_pa` is (descriptor[47:0] AND NOT mask) OR (input AND mask).
- R8: The leaf permission field is descriptor bits [7:6] and the table permission field is bits [62:61]. When bit 1 of the field is set the mapping is read-only, and a write request faults with 2'b10 at that descriptor's address. `res_perm` is {write, read} = {~AP[1], 1}.
- R9: A memory response with the error flag set gives fault 2'b11, with the address of the descriptor being read.
- R10: An invalid or reserved descriptor gives fault 2'b01 with that descriptor's address.
- R11: On any fault, `res_perm`, `res_pa` and `res_mask` are zero.
- R12: `req_ready` is high only while idle. `mem_req_valid` is a one-cycle pulse, and no new read is issued before the previous response. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Input address |
| req_write | input | 1 | 1 = write access, 0 = read |
| cfg_tbi_lo | input | 1 | Top-byte-ignore for bit55 = 0 |
| cfg_tbi_hi | input | 1 | Top-byte-ignore for bit55 = 1 |
| cfg_lo_size | input | 6 | Low region size field |
| cfg_hi_size | input | 6 | High region size field |
| cfg_lo_gran | input | 2 | Low region granule code |
| cfg_hi_gran | input | 2 | High region granule code |
| cfg_lo_base | input | 64 | Low region table base |
| cfg_hi_base | input | 64 | High region table base |
| cfg_lo_off | input | 1 | Low region disabled |
| cfg_hi_off | input | 1 | High region disabled |
| mem_req_valid | output | 1 | Descriptor read pulse |
| mem_req_addr | output | PA_W | Descriptor address |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | 64 | Descriptor |
| mem_rsp_err | input | 1 | Bus error on the read |
| done | output | 1 | Result pulse |
| res_pa | output | PA_W | Translated address |
| res_mask | output | PA_W | Mapping size mask |
| res_perm | output | 2 | {write, read} granted |
| res_fault | output | 2 | 00 none, 01 translation, 10 permission, 11 abort |
| res_fault_addr | output | PA_W | Faulting descriptor address |

## Verification
The bench goes after addresses in the gap between the regions, and after junk in the top byte with and without top-byte-ignore. A walker that tested the wrong bits would pick a region and read memory where a fault with no read is due. Clamped sizes and the 64 KiB case whose start level is 4 are covered, where wrong level arithmetic shows up as extra or missing reads and wrong descriptor addresses. Read-only table descriptors met by writes, reserved types at levels 0 and 3, and descriptors whose low bits below the granule or block size are junk are also mixed in. A design that used the wrong permission field, accepted a reserved type or failed to mask those bits returns a wrong fault code or a wrong address.

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker #(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_va,
  input  logic            req_write,
  input  logic            cfg_tbi_lo,
  input  logic            cfg_tbi_hi,
  input  logic [5:0]      cfg_lo_size,
  input  logic [5:0]      cfg_hi_size,
  input  logic [1:0]      cfg_lo_gran,
  input  logic [1:0]      cfg_hi_gran,
  input  logic [63:0]     cfg_lo_base,
  input  logic [63:0]     cfg_hi_base,
  input  logic            cfg_lo_off,
  input  logic            cfg_hi_off,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            done,
  output logic [PA_W-1:0] res_pa,
  output logic [PA_W-1:0] res_mask,
  output logic [1:0]      res_perm,
  output logic [1:0]      res_fault,
  output logic [PA_W-1:0] res_fault_addr
);
  localparam logic [1:0] F_NONE = 2'b00, F_XLAT = 2'b01, F_PERM = 2'b10, F_ABORT = 2'b11;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} state_t;

  function automatic logic [63:0] span(input logic [5:0] sz, input logic tbi);
    logic [63:0] m;
    for (int i = 0; i < 64; i++)
      m[i] = (i >= 64 - int'(sz)) && (i < (tbi ? 56 : 64));
    return m;
  endfunction

  state_t st;
  logic [63:0] va_q;
  logic        wr_q;
  logic [4:0]  g_q;
  logic [3:0]  sd_q;
  logic [5:0]  ins_q;
  logic [2:0]  lvl_q;
  logic [PA_W-1:0] base_q;

  // region choice
  logic tbi, in_lo, in_hi, pick_ok, pick_hi;
  logic [63:0] m_lo, m_hi;
  assign tbi   = req_va[55] ? cfg_tbi_hi : cfg_tbi_lo;
  assign m_lo  = span(cfg_lo_size, tbi);
  assign m_hi  = span(cfg_hi_size, tbi);
  assign in_lo = (cfg_lo_size != 6'd0) && ((req_va & m_lo) == 64'd0);
  assign in_hi = (cfg_hi_size != 6'd0) && ((req_va & m_hi) == m_hi);

  always_comb begin
    pick_ok = 1'b1;
    pick_hi = 1'b0;
    if (in_lo) pick_hi = 1'b0;
    else if (in_hi) pick_hi = 1'b1;
    else if (cfg_lo_size == 6'd0) pick_hi = 1'b0;
    else if (cfg_hi_size == 6'd0) pick_hi = 1'b1;
    else pick_ok = 1'b0;
  end

  logic [5:0]  sz_raw, sz_c;
  logic [1:0]  gsel;
  logic        off_sel;
  logic [63:0] base_sel;
  assign sz_raw   = pick_hi ? cfg_hi_size : cfg_lo_size;
  assign gsel     = pick_hi ? cfg_hi_gran : cfg_lo_gran;
  assign off_sel  = pick_hi ? cfg_hi_off  : cfg_lo_off;
  assign base_sel = pick_hi ? cfg_hi_base : cfg_lo_base;
  assign sz_c     = (sz_raw < 6'd16) ? 6'd16 : (sz_raw > 6'd48) ? 6'd48 : sz_raw;

  int g_n, sd_n, ins_n, lv_n, tb_n;
  logic [PA_W-1:0] base0;
  always_comb begin
    g_n   = (gsel == 2'd0) ? 12 : (gsel == 2'd1) ? 14 : 16;
    sd_n  = g_n - 3;
    ins_n = 64 - int'(sz_c);
    lv_n  = 4 - (ins_n - 4) / sd_n;
    tb_n  = ins_n - sd_n * (4 - lv_n);
    base0 = base_sel[PA_W-1:0] & ~((PA_W'(1) << tb_n) - PA_W'(1));
  end

  // per-level lookup
  int ls, nb;
  logic [63:0] idx;
  logic [PA_W-1:0] daddr, lmask, gmask, leaf_pa;
  always_comb begin
    ls = int'(g_q) + (3 - int'(lvl_q)) * int'(sd_q);
    nb = int'(ins_q) - ls;
    if (nb > int'(sd_q)) nb = int'(sd_q);
    idx     = (va_q >> ls) & ((64'd1 << nb) - 64'd1);
    daddr   = base_q + PA_W'(idx << 3);
    lmask   = (PA_W'(1) << ls) - PA_W'(1);
    gmask   = (PA_W'(1) << g_q) - PA_W'(1);
    leaf_pa = (mem_rsp_data[PA_W-1:0] & ~lmask) | (va_q[PA_W-1:0] & lmask);
  end

  logic [1:0] ty;
  logic is_page, is_block, is_tab;
  assign ty       = mem_rsp_data[1:0];
  assign is_page  = (lvl_q == 3'd3) && (ty == 2'b11);
  assign is_block = ((lvl_q == 3'd1) || (lvl_q == 3'd2)) && (ty == 2'b01);
  assign is_tab   = (lvl_q < 3'd3) && (ty == 2'b11);

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_FETCH);
  assign mem_req_addr  = daddr;
  assign done          = (st == S_DONE);

  logic unused_bits;
  assign unused_bits = ^{cfg_lo_base, cfg_hi_base, mem_rsp_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; wr_q <= 1'b0; g_q <= '0; sd_q <= '0; ins_q <= '0; lvl_q <= '0; base_q <= '0;
      res_pa <= '0; res_mask <= '0; res_perm <= '0; res_fault <= F_NONE; res_fault_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          g_q   <= 5'(g_n);
          sd_q  <= 4'(sd_n);
          ins_q <= 6'(ins_n);
          lvl_q <= 3'(lv_n);
          base_q <= base0;
          res_pa <= '0; res_mask <= '0; res_perm <= '0;
          res_fault <= F_NONE; res_fault_addr <= '0;
          if (!pick_ok || off_sel || lv_n > 3) begin
            res_fault <= F_XLAT;
            st <= S_DONE;
          end else st <= S_FETCH;
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            res_fault <= F_ABORT; res_fault_addr <= daddr; st <= S_DONE;
          end else if (is_page || is_block) begin
            if (wr_q && mem_rsp_data[7]) begin
              res_fault <= F_PERM; res_fault_addr <= daddr;
            end else begin
              res_pa <= leaf_pa; res_mask <= lmask; res_perm <= {~mem_rsp_data[7], 1'b1};
            end
            st <= S_DONE;
          end else if (is_tab) begin
            if (wr_q && mem_rsp_data[62]) begin
              res_fault <= F_PERM; res_fault_addr <= daddr; st <= S_DONE;
            end else begin
              base_q <= mem_rsp_data[PA_W-1:0] & ~gmask;
              lvl_q  <= lvl_q + 3'd1;
              st     <= S_FETCH;
            end
          end else begin
            res_fault <= F_XLAT; res_fault_addr <= daddr; st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done,
  input logic [PA_W-1:0] res_pa,
  input logic [PA_W-1:0] res_mask,
  input logic [1:0]      res_perm,
  input logic [1:0]      res_fault
);
  a_r12_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r5_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));
  a_r11_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault != 2'b00) |-> (res_perm == 2'b00 && res_pa == '0 && res_mask == '0));
  a_r8_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 2'b00) |-> res_perm[0]);
  a_r7_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 2'b00) |-> (((res_mask + PA_W'(1)) & res_mask) == '0 && res_mask != '0));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .done(done),
  .res_pa(res_pa), .res_mask(res_mask), .res_perm(res_perm), .res_fault(res_fault)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  localparam int PA_W = 48;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_va = '0;
  logic cfg_tbi_lo = 0, cfg_tbi_hi = 0, cfg_lo_off = 0, cfg_hi_off = 0;
  logic [5:0] cfg_lo_size = 6'd25, cfg_hi_size = 6'd25;
  logic [1:0] cfg_lo_gran = 0, cfg_hi_gran = 0;
  logic [63:0] cfg_lo_base = '0, cfg_hi_base = '0;
  logic mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [63:0] mem_rsp_data = '0;
  logic req_ready, mem_req_valid, done;
  logic [PA_W-1:0] mem_req_addr, res_pa, res_mask, res_fault_addr;
  logic [1:0] res_perm, res_fault;

  ptw_walker #(.PA_W(PA_W)) uut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, reads_seen = 0;
  logic [63:0] dmem [logic [47:0]];
  bit derr [logic [47:0]];

  // expectation
  logic [1:0] e_fault, e_perm;
  logic [47:0] e_pa, e_mask, e_faddr;
  int e_reads;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] span(input logic [5:0] sz, input logic tbi);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) if (i >= 64 - int'(sz) && i < (tbi ? 56 : 64)) m[i] = 1'b1;
    return m;
  endfunction

  // plants descriptors along the walk path and predicts the result
  // force_k: 0 random, 1 error at first level, 2 tables down to a page, 3 leaf at first usable level
  task automatic plan_walk(input logic [63:0] va, input logic wr, input int force_k);
    logic tbi, hi, ok;
    logic [63:0] m_lo, m_hi, bsel, desc, idx;
    logic [47:0] base, da, msk;
    int sz, g, sd, ins, sl, tb, ls, nb, k;
    dmem.delete(); derr.delete();
    e_fault = 0; e_perm = 0; e_pa = 0; e_mask = 0; e_faddr = 0; e_reads = 0;
    tbi = va[55] ? cfg_tbi_hi : cfg_tbi_lo;
    m_lo = span(cfg_lo_size, tbi); m_hi = span(cfg_hi_size, tbi);
    ok = 1; hi = 0;
    if (cfg_lo_size != 0 && (va & m_lo) == 0) hi = 0;
    else if (cfg_hi_size != 0 && (va & m_hi) == m_hi) hi = 1;
    else if (cfg_lo_size == 0) hi = 0;
    else if (cfg_hi_size == 0) hi = 1;
    else ok = 0;
    if (!ok) begin e_fault = 1; e_tag = "R1/R2"; return; end
    if (hi ? cfg_hi_off : cfg_lo_off) begin e_fault = 1; e_tag = "R3"; return; end
    sz = int'(hi ? cfg_hi_size : cfg_lo_size);
    if (sz < 16) sz = 16;
    if (sz > 48) sz = 48;
    k = int'(hi ? cfg_hi_gran : cfg_lo_gran);
    g = (k == 0) ? 12 : (k == 1) ? 14 : 16;
    sd = g - 3; ins = 64 - sz; sl = 4 - (ins - 4) / sd;
    if (sl > 3) begin e_fault = 1; e_tag = "R4"; return; end
    tb = ins - sd * (4 - sl);
    bsel = hi ? cfg_hi_base : cfg_lo_base;
    base = bsel[47:0] & ~((48'd1 << tb) - 48'd1);
    for (int lv = sl; lv <= 3; lv++) begin
      ls = g + (3 - lv) * sd;
      nb = ins - ls; if (nb > sd) nb = sd;
      idx = (va >> ls) & ((64'd1 << nb) - 64'd1);
      da = base + 48'(idx * 8);
      e_reads++;
      desc = {$urandom, $urandom};
      if (force_k == 1) k = 0;
      else if (force_k == 2) k = 99;
      else if (force_k == 3) k = (lv == 0) ? 99 : 30;
      else k = int'($urandom % 100);
      if (k < 6) begin
        derr[da] = 1; e_fault = 3; e_faddr = da; e_tag = "R5/R9"; return;
      end else if (k < 12 || (k < 16 && lv != 0 && lv != 3)) begin
        desc[0] = 1'b0; dmem[da] = desc; e_fault = 1; e_faddr = da; e_tag = "R6/R10"; return;
      end else if (k < 16) begin
        desc[1:0] = 2'b01; dmem[da] = desc; e_fault = 1; e_faddr = da; e_tag = "R6/R10"; return;
      end else if ((k < 36 && lv != 0) || lv == 3) begin
        desc[1:0] = (lv == 3) ? 2'b11 : 2'b01; dmem[da] = desc;
        msk = (48'd1 << ls) - 48'd1;
        if (wr && desc[7]) begin e_fault = 2; e_faddr = da; e_tag = "R8"; end
        else begin
          e_pa = (desc[47:0] & ~msk) | (va[47:0] & msk);
          e_mask = msk; e_perm = {~desc[7], 1'b1}; e_tag = "R6/R7/R8";
        end
        return;
      end else begin
        desc[1:0] = 2'b11; dmem[da] = desc;
        if (wr && desc[62]) begin e_fault = 2; e_faddr = da; e_tag = "R8"; return; end
        base = desc[47:0] & ~((48'd1 << g) - 48'd1);
      end
    end
  endtask

  task automatic do_walk(input logic [63:0] va, input logic wr, input int force_k);
    int n;
    plan_walk(va, wr, force_k);
    @(negedge clk);
    reads_seen = 0;
    chk(req_ready === 1'b1, "R12", "ready idle", 64'(req_ready), 64'd1);
    req_va = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R12", "ready busy", 64'(req_ready), 64'd0);
    n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(res_fault === e_fault, e_tag, "fault", 64'(res_fault), 64'(e_fault));
    chk(res_fault_addr === e_faddr, e_tag, "fault addr", 64'(res_fault_addr), 64'(e_faddr));
    chk(res_pa === e_pa, (e_fault != 0) ? "R11" : e_tag, "pa", 64'(res_pa), 64'(e_pa));
    chk(res_mask === e_mask, (e_fault != 0) ? "R11" : "R7", "mask", 64'(res_mask), 64'(e_mask));
    chk(res_perm === e_perm, (e_fault != 0) ? "R11" : "R8", "perm", 64'(res_perm), 64'(e_perm));
    chk(reads_seen == e_reads, (e_reads == 0) ? e_tag : "R4/R5", "reads", 64'(reads_seen), 64'(e_reads));
    @(negedge clk);
    chk(done === 1'b0, "R12", "done pulse", 64'(done), 64'd0);
  endtask

  // memory model: response one to three cycles after the request
  initial begin
    logic [47:0] a;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid === 1'b1) begin
        a = mem_req_addr;
        reads_seen++;
        repeat (1 + int'($urandom % 3)) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_err  = derr.exists(a);
        mem_rsp_data = dmem.exists(a) ? dmem[a] : 64'd0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] va;
    int r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R12", "reset ready", 64'(req_ready), 64'd1);
    chk(done === 1'b0, "R12", "reset done", 64'(done), 64'd0);
    chk(mem_req_valid === 1'b0, "R12", "reset read", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    cfg_lo_base = 64'h0000_1234_5678_9000; cfg_hi_base = 64'h0000_0abc_def0_0000;
    // R2: gap between the regions
    do_walk(64'h0000_4000_0000_0000, 1'b0, 0);
    // R1: junk top byte, bit55 set, high region with and without ignore
    cfg_tbi_hi = 1'b1; do_walk(64'h12FF_FF80_0000_1234, 1'b0, 2);
    cfg_tbi_hi = 1'b0; do_walk(64'h12FF_FF80_0000_1234, 1'b0, 2);
    // R3: disabled low region
    cfg_lo_off = 1'b1; do_walk(64'h0000_0000_0040_0000, 1'b0, 2); cfg_lo_off = 1'b0;
    // R4: 64 KiB with size 48 has start level 4
    cfg_lo_gran = 2'b10; cfg_lo_size = 6'd48; do_walk(64'h0000_0000_0000_0100, 1'b0, 2);
    // R4: size below 16 clamps, 4 KiB starts at level 0, full page chain
    cfg_lo_gran = 2'b00; cfg_lo_size = 6'd10; do_walk(64'h0000_7654_3210_fedc, 1'b1, 2);
    // R9: bus error at the first level
    cfg_lo_size = 6'd30; do_walk(64'h0000_0001_2345_6789, 1'b0, 1);
    // R7: block at first level, 64 KiB and 16 KiB
    cfg_lo_gran = 2'b11; cfg_lo_size = 6'd22; do_walk(64'h0000_0123_4567_89ab, 1'b0, 3);
    cfg_lo_gran = 2'b01; cfg_lo_size = 6'd28; do_walk(64'h0000_0000_0fed_cba9, 1'b0, 3);
    // R2: both sizes zero, low region takes all
    cfg_lo_size = 6'd0; cfg_hi_size = 6'd0; do_walk(64'hFFFF_0000_0000_1000, 1'b0, 2);
    for (int t = 0; t < 600; t++) begin
      cfg_lo_gran = 2'($urandom); cfg_hi_gran = 2'($urandom);
      cfg_lo_size = ($urandom % 20 == 0) ? 6'd0 : 6'(8 + $urandom % 45);
      cfg_hi_size = ($urandom % 20 == 0) ? 6'd0 : 6'(8 + $urandom % 45);
      cfg_tbi_lo = 1'($urandom); cfg_tbi_hi = 1'($urandom);
      cfg_lo_off = ($urandom % 30 == 0); cfg_hi_off = ($urandom % 30 == 0);
      cfg_lo_base = {$urandom, $urandom}; cfg_hi_base = {$urandom, $urandom};
      va = {$urandom, $urandom};
      r = int'($urandom % 3);
      if (r == 0) va = va & ((64'd1 << (64 - int'(cfg_lo_size))) - 64'd1);
      else if (r == 1) va = va | ~((64'd1 << (64 - int'(cfg_hi_size))) - 64'd1);
      if ($urandom % 2 == 1) va[63:56] = 8'($urandom);
      do_walk(va, 1'($urandom), 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule